// File: doc/BRIEF.md
# Dual-Slot Issue Gate

This block is the issue stage of a statically scheduled two-wide pipeline. Every fetch delivers one packet of two 32-bit instructions taken from an 8-byte aligned address. Slot 0 holds the arithmetic or branch operation and slot 1 holds the memory operation. Either slot may carry a no-op. The block receives the decoded fields of both slots and the load destination of the packet now in the execute stage. In each cycle it decides whether both slots issue, whether only slot 0 issues and slot 1 follows one cycle later, or whether the packet waits.

When a packet waits, `stall` tells the fetch side to hold the same packet on the inputs. A split packet takes two cycles. In the first cycle slot 0 issues with `stall` high. In the second cycle slot 1 issues alone with `replay1` high, and the packet is then consumed. The packet counter advances by 8 each time a packet is consumed. Two free-running counters, one of issued instructions and one of cycles, let the issue rate be measured over any window.

Top module: `dual_issue_gate`

## Requirements
- R1: While reset is held, and at the first sample after it, `issue0`, `issue1`, `stall`, `replay1` and `illegal` are 0, `pc` equals RESET_PC (default 0), and both counters are 0.
- R2: Kind codes are 0 no-op, 1 ALU, 2 branch, 3 load and 4 store. Slot 0 accepts only 0, 1 or 2, and slot 1 accepts only 0, 3 or 4. Any other code sets `illegal` and makes that slot issue nothing, while a legal non-no-op partner slot still issues.
- R3: A no-op slot never issues and adds nothing to the instruction count. With `pkt_valid` low, `issue0`, `issue1` and `stall` are all 0.
- R4: A valid packet of two legal, independent, non-no-op slots issues both slots in the same cycle with `stall` low, which is two instructions per cycle.
- R5: If slot 0 is an ALU operation whose destination is one of the registers that slot 1 reads, the packet splits. In the first cycle `issue0`=1, `issue1`=0 and `stall`=1. In the next cycle `issue0`=0, `issue1`=1, `replay1`=1 and `stall`=0. A load reads srca. A store reads srca (base) and srcb (data).
- R6: If `ex_ld_valid` is set and any active slot reads `ex_ld_dst`, neither slot issues and `stall`=1. ALU and branch read srca and srcb. During a replay cycle only slot 1 is examined.
- R7: Register 0 is never a hazard, either as a destination or as a source.
- R8: `pc` increases by 8 at every clock edge where `pkt_valid` is high and `stall` is low, and holds otherwise.
- R9: `instr_count` increases by `issue0`+`issue1` each cycle and `cycle_count` increases by 1 each cycle. A scheduled four-packet loop body of 5 instructions gives 5 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | A packet is present on the slot inputs |
| s0_kind | input | 3 | Slot 0 kind code |
| s0_dst | input | 5 | Slot 0 destination register |
| s0_srca | input | 5 | Slot 0 first source register |
| s0_srcb | input | 5 | Slot 0 second source register |
| s1_kind | input | 3 | Slot 1 kind code |
| s1_srca | input | 5 | Slot 1 base register |
| s1_srcb | input | 5 | Slot 1 store data register |
| ex_ld_valid | input | 1 | The execute stage holds a load |
| ex_ld_dst | input | 5 | Destination of that load |
| issue0 | output | 1 | Slot 0 issues this cycle |
| issue1 | output | 1 | Slot 1 issues this cycle |
| stall | output | 1 | Hold the current packet |
| replay1 | output | 1 | Slot 1 is issuing on its own after a split |
| illegal | output | 1 | A slot carries a kind that is not allowed in it |
| pc | output | 32 | Address of the packet being issued |
| instr_count | output | 32 | Instructions issued since reset |
| cycle_count | output | 32 | Cycles since reset |

## Verification
The assertions check properties that hold in every cycle. A stall never lets slot 1 issue. The first half of a split is always followed by a replay, and a replay never issues slot 0. Slot 0 never issues a memory kind. `pc` and the two counters move by exactly the amounts their rules give. Other behaviour depends on register numbers and on the order of packets, so only the bench scenarios show it. This covers which packets split and which stall on a load, the exemption of register 0, partial issue of illegal packets, and the 5-in-4 rate of the scheduled loop.

// File: rtl/dip_pkg.sv
package dip_pkg;
  typedef enum logic [2:0] {
    K_NOP = 3'd0,
    K_ALU = 3'd1,
    K_BR  = 3'd2,
    K_LD  = 3'd3,
    K_ST  = 3'd4
  } kind_e;

  // Slot roles are fixed: slot 0 arithmetic or branch, slot 1 memory.
  function automatic logic kind_fits(input logic slot, input logic [2:0] k);
    if (k == K_NOP) return 1'b1;
    if (!slot) return (k == K_ALU) || (k == K_BR);
    return (k == K_LD) || (k == K_ST);
  endfunction

  function automatic logic uses_a(input logic [2:0] k);
    return (k == K_ALU) || (k == K_BR) || (k == K_LD) || (k == K_ST);
  endfunction

  function automatic logic uses_b(input logic [2:0] k);
    return (k == K_ALU) || (k == K_BR) || (k == K_ST);
  endfunction

  // A register match that counts as a dependency; register 0 never does.
  function automatic logic reg_hit(input logic used, input logic [4:0] src,
                                   input logic [4:0] dst);
    return used && (dst != 5'd0) && (src == dst);
  endfunction
endpackage

// File: rtl/dip_slot_decode.sv
module dip_slot_decode #(
  parameter bit SLOT = 1'b0
) (
  input  logic [2:0] kind,
  output logic       active,
  output logic       bad,
  output logic       rd_a,
  output logic       rd_b
);
  import dip_pkg::*;
  logic fits;
  assign fits   = kind_fits(SLOT, kind);
  assign bad    = !fits;
  assign active = fits && (kind != K_NOP);
  assign rd_a   = active && uses_a(kind);
  assign rd_b   = active && uses_b(kind);
endmodule

// File: rtl/dip_hazard.sv
module dip_hazard #(
  parameter int REG_W = 5
) (
  input  logic [2:0]       s0_kind,
  input  logic [REG_W-1:0] s0_dst,
  input  logic [REG_W-1:0] s0_srca,
  input  logic [REG_W-1:0] s0_srcb,
  input  logic             s0_rd_a,
  input  logic             s0_rd_b,
  input  logic             s0_active,
  input  logic [REG_W-1:0] s1_srca,
  input  logic [REG_W-1:0] s1_srcb,
  input  logic             s1_rd_a,
  input  logic             s1_rd_b,
  input  logic             ex_ld_valid,
  input  logic [REG_W-1:0] ex_ld_dst,
  output logic             lu_hit0,
  output logic             lu_hit1,
  output logic             intra_hit
);
  import dip_pkg::*;
  logic s0_writes;
  assign s0_writes = s0_active && (s0_kind == K_ALU);

  assign lu_hit0 = ex_ld_valid &&
                   (reg_hit(s0_rd_a, s0_srca, ex_ld_dst) ||
                    reg_hit(s0_rd_b, s0_srcb, ex_ld_dst));
  assign lu_hit1 = ex_ld_valid &&
                   (reg_hit(s1_rd_a, s1_srca, ex_ld_dst) ||
                    reg_hit(s1_rd_b, s1_srcb, ex_ld_dst));
  assign intra_hit = s0_writes &&
                     (reg_hit(s1_rd_a, s1_srca, s0_dst) ||
                      reg_hit(s1_rd_b, s1_srcb, s0_dst));
endmodule

// File: rtl/dip_counters.sv
module dip_counters #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc0,
  input  logic             inc1,
  output logic [CNT_W-1:0] instr_count,
  output logic [CNT_W-1:0] cycle_count
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      instr_count <= '0;
      cycle_count <= '0;
    end else begin
      instr_count <= instr_count + CNT_W'(inc0) + CNT_W'(inc1);
      cycle_count <= cycle_count + CNT_W'(1);
    end
  end
endmodule

// File: rtl/dual_issue_gate.sv
module dual_issue_gate #(
  parameter int          REG_W    = 5,
  parameter int          PC_W     = 32,
  parameter int          CNT_W    = 32,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_valid,
  input  logic [2:0]       s0_kind,
  input  logic [REG_W-1:0] s0_dst,
  input  logic [REG_W-1:0] s0_srca,
  input  logic [REG_W-1:0] s0_srcb,
  input  logic [2:0]       s1_kind,
  input  logic [REG_W-1:0] s1_srca,
  input  logic [REG_W-1:0] s1_srcb,
  input  logic             ex_ld_valid,
  input  logic [REG_W-1:0] ex_ld_dst,
  output logic             issue0,
  output logic             issue1,
  output logic             stall,
  output logic             replay1,
  output logic             illegal,
  output logic [PC_W-1:0]  pc,
  output logic [CNT_W-1:0] instr_count,
  output logic [CNT_W-1:0] cycle_count
);
  localparam int          NSLOT     = 2;
  localparam logic [PC_W-1:0] PKT_BYTES = PC_W'(NSLOT * 4);

  logic [2:0]       kind_v [NSLOT];
  logic [NSLOT-1:0] act_v, bad_v, rda_v, rdb_v;

  assign kind_v[0] = s0_kind;
  assign kind_v[1] = s1_kind;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    dip_slot_decode #(.SLOT(g[0])) u_dec (
      .kind  (kind_v[g]),
      .active(act_v[g]),
      .bad   (bad_v[g]),
      .rd_a  (rda_v[g]),
      .rd_b  (rdb_v[g])
    );
  end

  // Named hazard events, brought out for the checker.
  logic lu_hit0, lu_hit1, intra_hit;
  dip_hazard #(.REG_W(REG_W)) u_haz (
    .s0_kind    (s0_kind),
    .s0_dst     (s0_dst),
    .s0_srca    (s0_srca),
    .s0_srcb    (s0_srcb),
    .s0_rd_a    (rda_v[0]),
    .s0_rd_b    (rdb_v[0]),
    .s0_active  (act_v[0]),
    .s1_srca    (s1_srca),
    .s1_srcb    (s1_srcb),
    .s1_rd_a    (rda_v[1]),
    .s1_rd_b    (rdb_v[1]),
    .ex_ld_valid(ex_ld_valid),
    .ex_ld_dst  (ex_ld_dst),
    .lu_hit0    (lu_hit0),
    .lu_hit1    (lu_hit1),
    .intra_hit  (intra_hit)
  );

  logic pending;     // slot 0 of the held packet has already issued
  logic split_now;

  always_comb begin
    issue0    = 1'b0;
    issue1    = 1'b0;
    stall     = 1'b0;
    replay1   = 1'b0;
    split_now = 1'b0;
    if (pkt_valid) begin
      if (pending) begin
        if (lu_hit1) stall = 1'b1;
        else begin
          issue1  = act_v[1];
          replay1 = 1'b1;
        end
      end else if (lu_hit0 || lu_hit1) begin
        stall = 1'b1;
      end else if (intra_hit) begin
        issue0    = 1'b1;
        stall     = 1'b1;
        split_now = 1'b1;
      end else begin
        issue0 = act_v[0];
        issue1 = act_v[1];
      end
    end
  end

  assign illegal = pkt_valid && (|bad_v);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      pc      <= RESET_PC[PC_W-1:0];
    end else begin
      if (pkt_valid) pending <= pending ? lu_hit1 : split_now;
      if (pkt_valid && !stall) pc <= pc + PKT_BYTES;
    end
  end

  dip_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .inc0       (issue0),
    .inc1       (issue1),
    .instr_count(instr_count),
    .cycle_count(cycle_count)
  );
endmodule

// File: rtl/dip_checker.sv
module dip_checker #(
  parameter int PC_W  = 32,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pkt_valid,
  input logic [2:0]       s0_kind,
  input logic             issue0,
  input logic             issue1,
  input logic             stall,
  input logic             replay1,
  input logic [PC_W-1:0]  pc,
  input logic [CNT_W-1:0] instr_count,
  input logic [CNT_W-1:0] cycle_count
);
  p_slot0_role_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && (s0_kind == 3'd3 || s0_kind == 3'd4)) |-> !issue0);

  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_valid |-> (!issue0 && !issue1 && !stall));

  p_split_replays_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (issue0 && stall) |=> (replay1 || (pkt_valid && stall)));

  p_replay_alone_r5: assert property (@(posedge clk) disable iff (!rst_n)
    replay1 |-> (!issue0 && issue1 && !stall));

  p_stall_holds_slot1_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !issue1);

  p_pc_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !stall) |=> (pc == $past(pc) + PC_W'(8)));

  p_pc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(pkt_valid && !stall) |=> $stable(pc));

  p_instr_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (instr_count == $past(instr_count) + CNT_W'($past(issue0))
                                                + CNT_W'($past(issue1))));

  p_cycle_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cycle_count == $past(cycle_count) + CNT_W'(1)));
endmodule

bind dual_issue_gate dip_checker #(.PC_W(PC_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pkt_valid  (pkt_valid),
  .s0_kind    (s0_kind),
  .issue0     (issue0),
  .issue1     (issue1),
  .stall      (stall),
  .replay1    (replay1),
  .pc         (pc),
  .instr_count(instr_count),
  .cycle_count(cycle_count)
);

// File: tb/dual_issue_gate_test.sv
`timescale 1ns/1ps
module dual_issue_gate_test;
  localparam logic [2:0] NOP = 3'd0, ALU = 3'd1, BR = 3'd2, LD = 3'd3, ST = 3'd4;

  logic clk = 1'b0, rst_n = 1'b0, pkt_valid = 1'b0;
  logic [2:0] s0_kind = NOP, s1_kind = NOP;
  logic [4:0] s0_dst = 0, s0_srca = 0, s0_srcb = 0, s1_srca = 0, s1_srcb = 0;
  logic ex_ld_valid = 1'b0;
  logic [4:0] ex_ld_dst = 0;
  logic issue0, issue1, stall, replay1, illegal;
  logic [31:0] pc, instr_count, cycle_count;
  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dual_issue_gate uut (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid),
    .s0_kind(s0_kind), .s0_dst(s0_dst), .s0_srca(s0_srca), .s0_srcb(s0_srcb),
    .s1_kind(s1_kind), .s1_srca(s1_srca), .s1_srcb(s1_srcb),
    .ex_ld_valid(ex_ld_valid), .ex_ld_dst(ex_ld_dst),
    .issue0(issue0), .issue1(issue1), .stall(stall), .replay1(replay1),
    .illegal(illegal), .pc(pc), .instr_count(instr_count), .cycle_count(cycle_count)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Put a packet on the inputs just after a falling edge, let it settle.
  task automatic put(input logic [2:0] k0, input logic [4:0] d0, input logic [4:0] a0,
                     input logic [4:0] b0, input logic [2:0] k1, input logic [4:0] a1,
                     input logic [4:0] b1, input logic exv, input logic [4:0] exd);
    @(negedge clk);
    pkt_valid = 1'b1;
    s0_kind = k0; s0_dst = d0; s0_srca = a0; s0_srcb = b0;
    s1_kind = k1; s1_srca = a1; s1_srcb = b1;
    ex_ld_valid = exv; ex_ld_dst = exd;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    pkt_valid = 1'b0; ex_ld_valid = 1'b0;
    #1;
  endtask

  task automatic outs(input string req, input logic i0, input logic i1, input logic st,
                      input logic rp, input logic il);
    chk(req, "issue0", 32'(issue0), 32'(i0));
    chk(req, "issue1", 32'(issue1), 32'(i1));
    chk(req, "stall", 32'(stall), 32'(st));
    chk(req, "replay1", 32'(replay1), 32'(rp));
    chk(req, "illegal", 32'(illegal), 32'(il));
  endtask

  task automatic t_reset();
    outs("R1", 0, 0, 0, 0, 0);
    chk("R1", "pc", pc, 32'h0);
    chk("R1", "instr_count", instr_count, 0);
    chk("R1", "cycle_count", cycle_count, 0);
    idle();
    chk("R3", "idle issue0", 32'(issue0), 0);
    chk("R3", "idle stall", 32'(stall), 0);
  endtask

  task automatic t_pair();
    logic [31:0] p0, n0;
    put(ALU, 5'd1, 5'd2, 5'd3, LD, 5'd5, 5'd0, 1'b0, 5'd0);
    p0 = pc; n0 = instr_count;
    outs("R4", 1, 1, 0, 0, 0);
    idle();
    chk("R8", "pc after pair", pc, p0 + 8);
    chk("R9", "count after pair", instr_count, n0 + 2);
    chk("R8", "pc holds idle", pc, p0 + 8);
  endtask

  task automatic t_split();
    logic [31:0] p0, n0;
    // r6 written by slot 0, stored as data by slot 1
    put(ALU, 5'd6, 5'd2, 5'd3, ST, 5'd7, 5'd6, 1'b0, 5'd0);
    p0 = pc; n0 = instr_count;
    outs("R5", 1, 0, 1, 0, 0);
    put(ALU, 5'd6, 5'd2, 5'd3, ST, 5'd7, 5'd6, 1'b0, 5'd0);
    outs("R5", 0, 1, 0, 1, 0);
    chk("R8", "pc held in split", pc, p0);
    idle();
    chk("R8", "pc after split", pc, p0 + 8);
    chk("R9", "count after split", instr_count, n0 + 2);
    // base register dependency also splits
    put(ALU, 5'd11, 5'd2, 5'd3, LD, 5'd11, 5'd0, 1'b0, 5'd0);
    outs("R5", 1, 0, 1, 0, 0);
    put(ALU, 5'd11, 5'd2, 5'd3, LD, 5'd11, 5'd0, 1'b0, 5'd0);
    outs("R5", 0, 1, 0, 1, 0);
    idle();
  endtask

  task automatic t_load_use();
    put(ALU, 5'd1, 5'd9, 5'd3, LD, 5'd5, 5'd0, 1'b1, 5'd9);
    outs("R6", 0, 0, 1, 0, 0);
    put(ALU, 5'd1, 5'd2, 5'd3, ST, 5'd4, 5'd9, 1'b1, 5'd9);
    outs("R6", 0, 0, 1, 0, 0);
    put(ALU, 5'd1, 5'd2, 5'd3, ST, 5'd4, 5'd9, 1'b0, 5'd9);
    outs("R6", 1, 1, 0, 0, 0);
    // split whose replay meets a load hit on slot 1
    put(ALU, 5'd12, 5'd2, 5'd3, LD, 5'd12, 5'd0, 1'b0, 5'd0);
    outs("R6", 1, 0, 1, 0, 0);
    put(ALU, 5'd12, 5'd2, 5'd3, LD, 5'd12, 5'd0, 1'b1, 5'd12);
    outs("R6", 0, 0, 1, 0, 0);
    put(ALU, 5'd12, 5'd2, 5'd3, LD, 5'd12, 5'd0, 1'b0, 5'd0);
    outs("R6", 0, 1, 0, 1, 0);
    idle();
  endtask

  task automatic t_zero();
    put(ALU, 5'd0, 5'd2, 5'd3, LD, 5'd0, 5'd0, 1'b1, 5'd0);
    outs("R7", 1, 1, 0, 0, 0);
    put(ALU, 5'd0, 5'd0, 5'd0, ST, 5'd0, 5'd0, 1'b0, 5'd0);
    outs("R7", 1, 1, 0, 0, 0);
    idle();
  endtask

  task automatic t_illegal();
    logic [31:0] n0;
    put(LD, 5'd1, 5'd2, 5'd3, LD, 5'd5, 5'd0, 1'b0, 5'd0);
    outs("R2", 0, 1, 0, 0, 1);
    put(ALU, 5'd1, 5'd2, 5'd3, ALU, 5'd5, 5'd6, 1'b0, 5'd0);
    outs("R2", 1, 0, 0, 0, 1);
    put(3'd7, 5'd1, 5'd2, 5'd3, 3'd6, 5'd5, 5'd6, 1'b0, 5'd0);
    n0 = instr_count;
    outs("R2", 0, 0, 0, 0, 1);
    idle();
    chk("R2", "count after all-illegal", instr_count, n0);
  endtask

  task automatic t_nop();
    logic [31:0] n0;
    put(NOP, 5'd1, 5'd2, 5'd3, LD, 5'd5, 5'd0, 1'b0, 5'd0);
    n0 = instr_count;
    outs("R3", 0, 1, 0, 0, 0);
    put(NOP, 5'd0, 5'd0, 5'd0, NOP, 5'd0, 5'd0, 1'b0, 5'd0);
    outs("R3", 0, 0, 0, 0, 0);
    idle();
    chk("R3", "count with nops", instr_count, n0 + 1);
  endtask

  // Scheduled loop body: r8 load value, r17 pointer, r18 scalar.
  task automatic t_loop();
    logic [31:0] n0, c0, p0;
    put(NOP, 5'd0, 5'd0, 5'd0, LD, 5'd17, 5'd0, 1'b0, 5'd0);
    n0 = instr_count; c0 = cycle_count; p0 = pc;
    outs("R9", 0, 1, 0, 0, 0);
    put(ALU, 5'd17, 5'd17, 5'd0, NOP, 5'd0, 5'd0, 1'b1, 5'd8);
    outs("R9", 1, 0, 0, 0, 0);
    put(ALU, 5'd8, 5'd8, 5'd18, NOP, 5'd0, 5'd0, 1'b0, 5'd0);
    outs("R9", 1, 0, 0, 0, 0);
    put(BR, 5'd0, 5'd17, 5'd0, ST, 5'd17, 5'd8, 1'b0, 5'd0);
    outs("R9", 1, 1, 0, 0, 0);
    idle();
    chk("R9", "loop instructions", instr_count - n0, 32'd5);
    chk("R9", "loop cycles", cycle_count - c0, 32'd4);
    chk("R8", "loop pc", pc, p0 + 32);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected<=20000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 outs("R1", 0, 0, 0, 0, 0);
    @(negedge clk) rst_n = 1'b1;
    #1;
    t_reset();
    t_pair();
    t_split();
    t_load_use();
    t_zero();
    t_illegal();
    t_nop();
    t_loop();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule